// File: doc/BRIEF.md
# Three-Kernel 3x3 Pixel Filter

This block turns one 3x3 neighbourhood of 8-bit grey pixels into one 8-bit filtered pixel. A two-bit kernel select picks an edge-enhancing Laplacian, a 1-2-1 smoothing Gaussian, or a Sobel gradient sum. Every scaling by a power of two is a shift. The intermediate values are signed 13-bit words, and the result is clamped into 0..255. The block sits behind a window-forming stage that presents one complete neighbourhood per cycle. The output is registered one cycle after each accepted window.

The nine inputs are named by compass position around the centre pixel `pix_c`. The top row is `pix_nw`, `pix_n`, `pix_ne`. The middle row is `pix_w`, `pix_c`, `pix_e`. The bottom row is `pix_sw`, `pix_s`, `pix_se`. Parameter `APPROX_LSBS` swaps every adder of non-negative operands for an inexact one. Such an adder computes its low bits as a bitwise OR and drops the carry out of them. Subtractions and the final Sobel combination stay exact.

The output side is a two-state machine:
- `ST_IDLE`: no output is valid.
- `ST_VALID`: `out_pix` holds a fresh result.

The transitions are named as follows:
- `T_ACCEPT`: an input was accepted. The machine moves from any state to `ST_VALID`.
- `T_DRAIN`: no input was accepted. The machine moves from any state to `ST_IDLE`.

Top module: `img3x3_filter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset with no accepted input, `out_valid` is 0 and `out_pix` is 0.
- R2: `in_ready` is always 1. When `in_valid` is 1 at a rising clock edge, `out_valid` is 1 after that edge (`T_ACCEPT`). When `in_valid` is 0 at an edge, `out_valid` is 0 after it (`T_DRAIN`).
- R3: `out_pix` keeps its value across any edge at which no input is accepted.
- R4: With `mode` = 2'b00 (Laplacian), the result is the adder tree ((nw+n)+(ne+w)) + ((e+sw)+(s+se)) minus 4·c. The product 4·c is formed by a left shift of two.
- R5: With `mode` = 2'b01 (Gaussian), the result is (((nw+2n)+(ne+2w)) + ((sw+2s)+(4c+2e))) + se, shifted right by four.
- R6: With `mode[1]` = 1 (2'b10 or 2'b11, Sobel), the result is gx+gy. Here gx = ((nw+sw)+2w) − ((ne+se)+2e) and gy = ((nw+ne)+2n) − ((sw+se)+2s). The centre pixel has no effect, and no absolute value is taken.
- R7: In every mode, a result below 0 outputs 0 and a result above 255 outputs 255.
- R8: With `APPROX_LSBS` = L > 0, each addition in R4–R6 of two non-negative operands is computed differently. Its low L bits are the bitwise OR of the operands, and its upper bits are the sum of the operands' upper bits with no carry in. The subtractions, the 4·c term and the gx+gy sum stay exact. L = 0 is the exact design.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Always 1: a window is taken every cycle |
| mode | input | 2 | 00 Laplacian, 01 Gaussian, 1x Sobel |
| pix_nw | input | 8 | Top-left pixel |
| pix_n | input | 8 | Top-middle pixel |
| pix_ne | input | 8 | Top-right pixel |
| pix_w | input | 8 | Middle-left pixel |
| pix_c | input | 8 | Centre pixel |
| pix_e | input | 8 | Middle-right pixel |
| pix_sw | input | 8 | Bottom-left pixel |
| pix_s | input | 8 | Bottom-middle pixel |
| pix_se | input | 8 | Bottom-right pixel |
| out_valid | output | 1 | Result valid |
| out_pix | output | 8 | Clamped filtered pixel |

## Verification
The hardest behaviour to reach from the ports is the inexact-adder arithmetic. Its errors appear only when operand low bits overlap, and they are masked whenever the result saturates. A second instance with three approximate bits is therefore driven with the same random windows as the exact one. Small pixel values are mixed into the stimulus so that many results stay inside 0..255, where the dropped carries are visible. Directed windows reach both clamp rails and confirm that the Sobel result does not depend on the centre pixel. A pause in `in_valid` shows that the held output does not move.

// File: rtl/img3x3_pkg.sv
package img3x3_pkg;
    localparam int PIX_W  = 8;
    localparam int WORD_W = 13;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef enum logic [1:0] {
        K_LAPLACE = 2'b00,
        K_GAUSS   = 2'b01,
        K_SOBEL   = 2'b10,
        K_SOBEL_B = 2'b11
    } kernel_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;
endpackage

// File: rtl/approx_add.sv
module approx_add #(
    parameter int W = 13,
    parameter int LSBS = 0
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    generate
        if (LSBS == 0) begin : g_exact
            assign s = x + y;
        end else begin : g_approx
            logic [W-LSBS-1:0] hi;
            assign hi = x[W-1:LSBS] + y[W-1:LSBS];
            assign s  = {hi, x[LSBS-1:0] | y[LSBS-1:0]};
        end
    endgenerate
endmodule

// File: rtl/lap_core.sv
module lap_core #(
    parameter int PW = 8,
    parameter int W = 13,
    parameter int LSBS = 0
) (
    input  logic [PW-1:0] nw, n, ne, w, c, e, sw, s, se,
    output logic signed [W-1:0] res
);
    localparam int PAD = W - PW;
    logic [W-1:0] v [8];
    logic [W-1:0] lvl1 [4];
    logic [W-1:0] lvl2 [2];
    logic [W-1:0] total;
    logic [W-1:0] c4;

    assign v[0] = {{PAD{1'b0}}, nw};
    assign v[1] = {{PAD{1'b0}}, n};
    assign v[2] = {{PAD{1'b0}}, ne};
    assign v[3] = {{PAD{1'b0}}, w};
    assign v[4] = {{PAD{1'b0}}, e};
    assign v[5] = {{PAD{1'b0}}, sw};
    assign v[6] = {{PAD{1'b0}}, s};
    assign v[7] = {{PAD{1'b0}}, se};

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_l1
            approx_add #(.W(W), .LSBS(LSBS)) u_add (.x(v[2*k]), .y(v[2*k+1]), .s(lvl1[k]));
        end
        for (k = 0; k < 2; k++) begin : g_l2
            approx_add #(.W(W), .LSBS(LSBS)) u_add (.x(lvl1[2*k]), .y(lvl1[2*k+1]), .s(lvl2[k]));
        end
    endgenerate
    approx_add #(.W(W), .LSBS(LSBS)) u_top (.x(lvl2[0]), .y(lvl2[1]), .s(total));

    assign c4  = {{PAD{1'b0}}, c} << 2;
    assign res = $signed(total) - $signed(c4);
endmodule

// File: rtl/gauss_core.sv
module gauss_core #(
    parameter int PW = 8,
    parameter int W = 13,
    parameter int LSBS = 0
) (
    input  logic [PW-1:0] nw, n, ne, w, c, e, sw, s, se,
    output logic signed [W-1:0] res
);
    localparam int PAD = W - PW;
    logic [W-1:0] lo_op [4];
    logic [W-1:0] hi_op [4];
    logic [W-1:0] part [4];
    logic [W-1:0] q0, q1, r, t;

    assign lo_op[0] = {{PAD{1'b0}}, nw};
    assign hi_op[0] = {{PAD{1'b0}}, n} << 1;
    assign lo_op[1] = {{PAD{1'b0}}, ne};
    assign hi_op[1] = {{PAD{1'b0}}, w} << 1;
    assign lo_op[2] = {{PAD{1'b0}}, sw};
    assign hi_op[2] = {{PAD{1'b0}}, s} << 1;
    assign lo_op[3] = {{PAD{1'b0}}, c} << 2;
    assign hi_op[3] = {{PAD{1'b0}}, e} << 1;

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_part
            approx_add #(.W(W), .LSBS(LSBS)) u_add (.x(lo_op[k]), .y(hi_op[k]), .s(part[k]));
        end
    endgenerate
    approx_add #(.W(W), .LSBS(LSBS)) u_q0 (.x(part[0]), .y(part[1]), .s(q0));
    approx_add #(.W(W), .LSBS(LSBS)) u_q1 (.x(part[2]), .y(part[3]), .s(q1));
    approx_add #(.W(W), .LSBS(LSBS)) u_r  (.x(q0), .y(q1), .s(r));
    approx_add #(.W(W), .LSBS(LSBS)) u_t  (.x(r), .y({{PAD{1'b0}}, se}), .s(t));

    assign res = $signed(t >> 4);
endmodule

// File: rtl/sobel_core.sv
module sobel_core #(
    parameter int PW = 8,
    parameter int W = 13,
    parameter int LSBS = 0
) (
    input  logic [PW-1:0] nw, n, ne, w, e, sw, s, se,
    output logic signed [W-1:0] res
);
    localparam int PAD = W - PW;
    // pair order: gx plus, gx minus, gy plus, gy minus
    logic [W-1:0] p_x [4];
    logic [W-1:0] p_y [4];
    logic [W-1:0] dbl [4];
    logic [W-1:0] pr  [4];
    logic [W-1:0] grp [4];
    logic signed [W-1:0] gx, gy;

    assign p_x[0] = {{PAD{1'b0}}, nw}; assign p_y[0] = {{PAD{1'b0}}, sw}; assign dbl[0] = {{PAD{1'b0}}, w} << 1;
    assign p_x[1] = {{PAD{1'b0}}, ne}; assign p_y[1] = {{PAD{1'b0}}, se}; assign dbl[1] = {{PAD{1'b0}}, e} << 1;
    assign p_x[2] = {{PAD{1'b0}}, nw}; assign p_y[2] = {{PAD{1'b0}}, ne}; assign dbl[2] = {{PAD{1'b0}}, n} << 1;
    assign p_x[3] = {{PAD{1'b0}}, sw}; assign p_y[3] = {{PAD{1'b0}}, se}; assign dbl[3] = {{PAD{1'b0}}, s} << 1;

    genvar k;
    generate
        for (k = 0; k < 4; k++) begin : g_grp
            approx_add #(.W(W), .LSBS(LSBS)) u_pair (.x(p_x[k]), .y(p_y[k]), .s(pr[k]));
            approx_add #(.W(W), .LSBS(LSBS)) u_dbl  (.x(pr[k]), .y(dbl[k]), .s(grp[k]));
        end
    endgenerate

    assign gx  = $signed(grp[0]) - $signed(grp[1]);
    assign gy  = $signed(grp[2]) - $signed(grp[3]);
    assign res = gx + gy;
endmodule

// File: rtl/img3x3_filter.sv
module img3x3_filter
    import img3x3_pkg::*;
#(
    parameter int APPROX_LSBS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       mode,
    input  logic [PIX_W-1:0] pix_nw,
    input  logic [PIX_W-1:0] pix_n,
    input  logic [PIX_W-1:0] pix_ne,
    input  logic [PIX_W-1:0] pix_w,
    input  logic [PIX_W-1:0] pix_c,
    input  logic [PIX_W-1:0] pix_e,
    input  logic [PIX_W-1:0] pix_sw,
    input  logic [PIX_W-1:0] pix_s,
    input  logic [PIX_W-1:0] pix_se,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    localparam logic signed [WORD_W-1:0] SAT_HI = WORD_W'(PIX_MAX);

    out_state_e state_q, state_d;
    logic signed [WORD_W-1:0] lap_r, gau_r, sob_r, sel_r;
    logic [PIX_W-1:0] clamped;
    logic accept;

    assign in_ready = 1'b1;
    assign accept   = in_valid && in_ready;

    lap_core #(.PW(PIX_W), .W(WORD_W), .LSBS(APPROX_LSBS)) u_lap (
        .nw(pix_nw), .n(pix_n), .ne(pix_ne), .w(pix_w), .c(pix_c),
        .e(pix_e), .sw(pix_sw), .s(pix_s), .se(pix_se), .res(lap_r));

    gauss_core #(.PW(PIX_W), .W(WORD_W), .LSBS(APPROX_LSBS)) u_gau (
        .nw(pix_nw), .n(pix_n), .ne(pix_ne), .w(pix_w), .c(pix_c),
        .e(pix_e), .sw(pix_sw), .s(pix_s), .se(pix_se), .res(gau_r));

    sobel_core #(.PW(PIX_W), .W(WORD_W), .LSBS(APPROX_LSBS)) u_sob (
        .nw(pix_nw), .n(pix_n), .ne(pix_ne), .w(pix_w),
        .e(pix_e), .sw(pix_sw), .s(pix_s), .se(pix_se), .res(sob_r));

    always_comb begin
        unique case (kernel_e'(mode))
            K_LAPLACE:          sel_r = lap_r;
            K_GAUSS:            sel_r = gau_r;
            K_SOBEL, K_SOBEL_B: sel_r = sob_r;
        endcase
    end

    always_comb begin
        if (sel_r < 0)           clamped = '0;
        else if (sel_r > SAT_HI) clamped = PIX_W'(PIX_MAX);
        else                     clamped = sel_r[PIX_W-1:0];
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = accept ? ST_VALID : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      out_pix <= '0;
        else if (accept) out_pix <= clamped;
    end

    assign out_valid = (state_q == ST_VALID);
endmodule

// File: rtl/img3x3_filter_chk.sv
module img3x3_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] mode,
    input logic [7:0] pix_nw, pix_n, pix_ne, pix_w, pix_e, pix_sw, pix_s, pix_se,
    input logic       out_valid,
    input logic [7:0] out_pix
);
    logic flat_sob;
    assign flat_sob = mode[1] && (pix_nw == pix_n) && (pix_n == pix_ne) &&
                      (pix_ne == pix_w) && (pix_w == pix_e) && (pix_e == pix_sw) &&
                      (pix_sw == pix_s) && (pix_s == pix_se);

    // R2
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    drain_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pix));

    // R6
    sobel_flat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flat_sob) |=> (out_pix == 8'd0));
endmodule

bind img3x3_filter img3x3_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .pix_nw(pix_nw), .pix_n(pix_n), .pix_ne(pix_ne), .pix_w(pix_w),
    .pix_e(pix_e), .pix_sw(pix_sw), .pix_s(pix_s), .pix_se(pix_se),
    .out_valid(out_valid), .out_pix(out_pix));

// File: tb/img3x3_filter_bench.sv
`timescale 1ns/1ps
module img3x3_filter_bench;
    localparam int APX = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] px [9];
    logic rdy0, rdy1, ov0, ov1;
    logic [7:0] op0, op1;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    img3x3_filter #(.APPROX_LSBS(0)) u_img3x3_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0), .mode(mode),
        .pix_nw(px[0]), .pix_n(px[1]), .pix_ne(px[2]), .pix_w(px[3]), .pix_c(px[4]),
        .pix_e(px[5]), .pix_sw(px[6]), .pix_s(px[7]), .pix_se(px[8]),
        .out_valid(ov0), .out_pix(op0));

    img3x3_filter #(.APPROX_LSBS(APX)) u_img3x3_filter_apx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1), .mode(mode),
        .pix_nw(px[0]), .pix_n(px[1]), .pix_ne(px[2]), .pix_w(px[3]), .pix_c(px[4]),
        .pix_e(px[5]), .pix_sw(px[6]), .pix_s(px[7]), .pix_se(px[8]),
        .out_valid(ov1), .out_pix(op1));

    function automatic int ad(int x, int y, int l);
        int m = (1 << l) - 1;
        return ((((x >> l) + (y >> l)) << l) | ((x | y) & m)) & 13'h1fff;
    endfunction

    function automatic int model(int p[9], int m, int l);
        int r, gx, gy;
        if (m >= 2) begin
            gx = ad(ad(p[0], p[6], l), 2*p[3], l) - ad(ad(p[2], p[8], l), 2*p[5], l);
            gy = ad(ad(p[0], p[2], l), 2*p[1], l) - ad(ad(p[6], p[8], l), 2*p[7], l);
            r = gx + gy;
        end else if (m == 1) begin
            r = ad(ad(ad(ad(p[0], 2*p[1], l), ad(p[2], 2*p[3], l), l),
                      ad(ad(p[6], 2*p[7], l), ad(4*p[4], 2*p[5], l), l), l), p[8], l) >> 4;
        end else begin
            r = ad(ad(ad(p[0], p[1], l), ad(p[2], p[3], l), l),
                   ad(ad(p[5], p[6], l), ad(p[7], p[8], l), l), l) - 4*p[4];
        end
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // at a negedge: drive one window, wait one negedge, compare both instances
    task automatic step(int p[9], int m, string tag);
        for (int k = 0; k < 9; k++) px[k] = 8'(p[k]);
        mode = 2'(m);
        in_valid = 1'b1;
        @(negedge clk);
        chk({tag, " valid"}, int'(ov0), 1);
        chk({tag, " exact"}, int'(op0), model(p, m, 0));
        chk({tag, " approx R8"}, int'(op1), model(p, m, APX));
    endtask

    task automatic fill(output int p[9], input int v);
        for (int k = 0; k < 9; k++) p[k] = v;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int p[9];
        int held;
        void'($urandom(32'd1234));
        for (int k = 0; k < 9; k++) px[k] = 8'd0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 out_valid in reset", int'(ov0), 0);
        chk("R1 out_pix in reset", int'(op0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(ov0), 0);
        chk("R1 out_pix after reset", int'(op0), 0);
        chk("R2 in_ready", int'(rdy0), 1);

        // R4 directed: flat max clamps high, hot centre clamps low
        fill(p, 255); step(p, 0, "R4 R7 lap flat 255");
        chk("R7 lap high rail", int'(op0), 255);
        fill(p, 0); p[4] = 255; step(p, 0, "R4 R7 lap hot centre");
        chk("R7 lap low rail", int'(op0), 0);
        fill(p, 10); p[4] = 5; step(p, 0, "R4 lap mid");
        chk("R4 lap value", int'(op0), 60);
        // R5 directed
        fill(p, 255); step(p, 1, "R5 gauss flat 255");
        chk("R5 gauss flat", int'(op0), 255);
        fill(p, 0); p[4] = 100; step(p, 1, "R5 gauss centre");
        chk("R5 gauss centre value", int'(op0), 25);
        // R6 directed
        fill(p, 0); p[0] = 10; step(p, 2, "R6 sobel corner");
        chk("R6 sobel corner value", int'(op0), 20);
        fill(p, 0); p[8] = 10; step(p, 3, "R6 R7 sobel negative");
        chk("R7 sobel negative clamps", int'(op0), 0);
        fill(p, 0); p[0] = 200; p[4] = 0; step(p, 2, "R6 centre 0");
        chk("R7 sobel high rail", int'(op0), 255);
        fill(p, 0); p[0] = 50; p[4] = 0; step(p, 2, "R6 centre 0 small");
        held = int'(op0);
        p[4] = 255; step(p, 2, "R6 centre 255 small");
        chk("R6 centre ignored", int'(op0), held);

        // R2 / R3: pause input, output must drop valid and hold value
        held = int'(op0);
        in_valid = 1'b0;
        for (int k = 0; k < 9; k++) px[k] = 8'd77;
        mode = 2'b00;
        @(negedge clk);
        chk("R2 drain valid", int'(ov0), 0);
        chk("R3 hold pix", int'(op0), held);
        @(negedge clk);
        chk("R3 hold pix 2", int'(op0), held);

        // random windows across all modes, half of them small-valued
        for (int n = 0; n < 600; n++) begin
            int lim;
            lim = ($urandom % 2) ? 256 : 24;
            for (int k = 0; k < 9; k++) p[k] = int'($urandom % lim);
            step(p, int'($urandom % 4), "R4 R5 R6 random");
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2 final drain", int'(ov0), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule